// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block keeps wall-clock time and a calendar. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year offset from a base year. A one-second `tick` advances an internal binary counter. After a short update window, the counter is re-encoded into the visible time bytes. The visible bytes are shown as BCD or plain binary, and hours in 24-hour or 12-hour form, as two mode bits select. At the end of every update window the block compares three alarm bytes (seconds, minutes, hours) against the new time. It then pulses an update-ended flag, and an alarm flag when the alarm is enabled and matches.

Software reaches every field through a single valid/ready load port. A field select picks the byte, and a beat completes in a cycle where `ld_valid` and `ld_ready` are both high. The block applies back-pressure by holding `ld_ready` low in two cases: in the cycle where `tick` is asserted, and for the whole update window. The source must then hold its beat until ready returns. The flag pulses go to a separate status block, which latches and clears them.

Top module: `rtc_calendar`

## Requirements
- R1: Each accepted tick advances seconds 0..59, carries into minutes 0..59, then hours 0..23, then day of week, which runs 1..7 and wraps from 7 to 1.
- R2: Day of month wraps to 1 after the month length (31,28,31,30,31,30,31,31,30,31,30,31). February has 29 days when BASE_YEAR plus the year offset is divisible by 4, except centuries not divisible by 400. Month wraps from 12 to 1 and increments the year offset, which wraps from 99 to 0.
- R3: With mode bit 2 of the mode byte clear, each visible byte holds value v as (v/10)*16 + v%10. With that bit set, the byte holds v unchanged.
- R4: With mode bit 1 clear (12-hour), the hour byte holds hour mod 12, with bit 7 set for hours 12..23. A loaded hour byte is read back the same way: bit 7 adds 12.
- R5: A tick is accepted only when bits 6:4 of the rate byte equal 010. Otherwise the tick changes no output.
- R6: After an accepted tick outside set mode, rate-byte bit 7 reads 1 for exactly UIP_CYCLES `osc_en` strobes. It clears in the cycle where the refreshed bytes and flags appear. Writes to that bit are ignored.
- R7: `ld_ready` is low while `tick` is high and during the update window. Field select codes: 0 sec, 1 min, 2 hour, 3 weekday, 4 day of month, 5 month, 6 year, 7/8/9 alarm sec/min/hour, 10 rate byte, 11 mode byte. Codes 12..15 change nothing.
- R8: While mode bit 7 (set) is 1, the visible time bytes are not refreshed, although time keeps counting. Clearing that bit loads the counter from the visible bytes. Outside set mode, a time-byte load reloads the counter at once.
- R9: `update_flag_o` pulses for one cycle at the end of every update window. `alarm_flag_o` pulses with it when mode bit 5 is set and each alarm byte matches. An alarm byte with bits 7:6 = 11 matches anything; otherwise it must equal the field.
- R10: A load that changes mode bit 2 or bit 1 outside set mode re-encodes the visible bytes from the counter in the same cycle.
- R11: After reset, the time is 00:00:00, weekday 1, day 1, month 1, year 0. The rate byte reads 0x20, the mode byte 0x02, both flags are low and `ld_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance pulse |
| osc_en | input | 1 | Strobe at the 32.768 kHz rate, used to time the update window |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat accepted when high with ld_valid |
| ld_sel | input | 4 | Field select of the load beat |
| ld_data | input | 8 | Byte to write |
| sec_o | output | 8 | Visible seconds |
| min_o | output | 8 | Visible minutes |
| hour_o | output | 8 | Visible hours (bit 7 = PM in 12-hour mode) |
| wday_o | output | 8 | Visible day of week |
| mday_o | output | 8 | Visible day of month |
| month_o | output | 8 | Visible month |
| year_o | output | 8 | Visible year offset |
| ctrl_a_o | output | 8 | Rate byte; bit 7 = update in progress |
| ctrl_b_o | output | 8 | Mode byte |
| alarm_flag_o | output | 1 | Alarm match pulse |
| update_flag_o | output | 1 | Update-ended pulse |

## Verification
The hardest states to reach by counting ticks alone are the month ends. The year rollover and the leap and century cases would take millions of ticks. The stimulus instead loads 23:59:59 on the last day of each month through the load port, in leap, ordinary and century years, and applies one tick. A load in set mode followed by leaving set mode shows that the counter takes the visible bytes and not its own running value.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] SEL_SEC  = 4'd0;
  localparam logic [SEL_W-1:0] SEL_MIN  = 4'd1;
  localparam logic [SEL_W-1:0] SEL_HOUR = 4'd2;
  localparam logic [SEL_W-1:0] SEL_WDAY = 4'd3;
  localparam logic [SEL_W-1:0] SEL_MDAY = 4'd4;
  localparam logic [SEL_W-1:0] SEL_MON  = 4'd5;
  localparam logic [SEL_W-1:0] SEL_YEAR = 4'd6;
  localparam logic [SEL_W-1:0] SEL_ASEC = 4'd7;
  localparam logic [SEL_W-1:0] SEL_AMIN = 4'd8;
  localparam logic [SEL_W-1:0] SEL_AHR  = 4'd9;
  localparam logic [SEL_W-1:0] SEL_CTLA = 4'd10;
  localparam logic [SEL_W-1:0] SEL_CTLB = 4'd11;

  // mode byte bit positions
  localparam int MB_SET = 7;
  localparam int MB_AIE = 5;
  localparam int MB_BIN = 2;
  localparam int MB_H24 = 1;

  localparam logic [2:0] DIV_RUN = 3'b010;
  localparam int ALM_N      = 3;
  localparam int ALM_HR_IDX = 2;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] dom;
    logic [2:0] dow;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } disp_t;

  function automatic logic [7:0] to_disp(input logic [6:0] v, input logic bin);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return bin ? {1'b0, v} : {tens, ones};
  endfunction

  function automatic logic [6:0] from_disp(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : (7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [11:0] fy);
    logic leap;
    leap = (fy % 12'd4 == 12'd0) &&
           ((fy % 12'd100 != 12'd0) || (fy % 12'd400 == 12'd0));
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step import rtc_cal_pkg::*; #(
  parameter int BASE_YEAR = 2000
) (
  input  cal_t cur,
  output cal_t nxt
);
  logic [11:0] full_year;
  logic [4:0]  mdays;

  assign full_year = 12'(BASE_YEAR) + 12'(cur.yr);
  assign mdays     = month_days(cur.mon, full_year);

  always_comb begin
    nxt = cur;
    if (cur.sec >= 6'd59) begin
      nxt.sec = 6'd0;
      if (cur.min >= 6'd59) begin
        nxt.min = 6'd0;
        if (cur.hr >= 5'd23) begin
          nxt.hr  = 5'd0;
          nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
          if (cur.dom >= mdays) begin
            nxt.dom = 5'd1;
            if (cur.mon >= 4'd12) begin
              nxt.mon = 4'd1;
              nxt.yr  = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
            end else begin
              nxt.mon = cur.mon + 4'd1;
            end
          end else begin
            nxt.dom = cur.dom + 5'd1;
          end
        end else begin
          nxt.hr = cur.hr + 5'd1;
        end
      end else begin
        nxt.min = cur.min + 6'd1;
      end
    end else begin
      nxt.sec = cur.sec + 6'd1;
    end
  end
endmodule

// File: rtl/rtc_cal_encode.sv
module rtc_cal_encode import rtc_cal_pkg::*; (
  input  cal_t  c,
  input  logic  bin,
  input  logic  h24,
  output disp_t d
);
  logic       pm;
  logic [6:0] h12;

  always_comb begin
    pm    = (c.hr >= 5'd12);
    h12   = pm ? 7'(c.hr - 5'd12) : 7'(c.hr);
    d.sec = to_disp(7'(c.sec), bin);
    d.min = to_disp(7'(c.min), bin);
    d.hr  = h24 ? to_disp(7'(c.hr), bin) : (to_disp(h12, bin) | {pm, 7'd0});
    d.dow = to_disp(7'(c.dow), bin);
    d.dom = to_disp(7'(c.dom), bin);
    d.mon = to_disp(7'(c.mon), bin);
    d.yr  = to_disp(c.yr, bin);
  end
endmodule

// File: rtl/rtc_cal_decode.sv
module rtc_cal_decode import rtc_cal_pkg::*; (
  input  disp_t d,
  input  logic  bin,
  input  logic  h24,
  output cal_t  c
);
  logic [6:0] hraw;

  always_comb begin
    hraw = from_disp({1'b0, d.hr[6:0]}, bin);
    if (!h24 && d.hr[7]) hraw = hraw + 7'd12;
    c.sec = 6'(from_disp(d.sec, bin));
    c.min = 6'(from_disp(d.min, bin));
    c.hr  = 5'(hraw);
    c.dow = 3'(from_disp(d.dow, bin));
    c.dom = 5'(from_disp(d.dom, bin));
    c.mon = 4'(from_disp(d.mon, bin));
    c.yr  = from_disp(d.yr, bin);
  end
endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm import rtc_cal_pkg::*; #(
  parameter int NFIELD = ALM_N,
  parameter int HR_IDX = ALM_HR_IDX
) (
  input  logic                    en,
  input  logic                    bin,
  input  logic                    h24,
  input  logic [NFIELD-1:0][7:0]  alm,
  input  logic [NFIELD-1:0][6:0]  cur,
  output logic                    hit
);
  logic [NFIELD-1:0] match;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    logic [6:0] dv;
    if (i == HR_IDX) begin : g_hr
      always_comb begin
        dv = from_disp({1'b0, alm[i][6:0]}, bin);
        if (!h24 && alm[i][7]) dv = dv + 7'd12;
      end
    end else begin : g_plain
      always_comb dv = from_disp(alm[i], bin);
    end
    assign match[i] = (alm[i][7:6] == 2'b11) || (dv == cur[i]);
  end

  assign hit = en && (&match);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_cal_pkg::*; #(
  parameter int BASE_YEAR  = 2000,
  parameter int UIP_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             osc_en,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [7:0]       ld_data,
  output logic [7:0]       sec_o,
  output logic [7:0]       min_o,
  output logic [7:0]       hour_o,
  output logic [7:0]       wday_o,
  output logic [7:0]       mday_o,
  output logic [7:0]       month_o,
  output logic [7:0]       year_o,
  output logic [7:0]       ctrl_a_o,
  output logic [7:0]       ctrl_b_o,
  output logic             alarm_flag_o,
  output logic             update_flag_o
);
  localparam int WCW = $clog2(UIP_CYCLES + 1);
  localparam logic [WCW-1:0] WLAST = WCW'(UIP_CYCLES - 1);

  localparam cal_t  CAL_RST  = '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd1,
                                 hr: 5'd0, min: 6'd0, sec: 6'd0};
  localparam disp_t DISP_RST = '{yr: 8'h00, mon: 8'h01, dom: 8'h01, dow: 8'h01,
                                 hr: 8'h00, min: 8'h00, sec: 8'h00};

  cal_t                   cnt, stp, dec_c, enc_src;
  disp_t                  vis, vis_nx, enc_v;
  logic [ALM_N-1:0][7:0]  alm_r;
  logic [ALM_N-1:0][6:0]  alm_cur;
  logic [6:0]             ctla;
  logic [7:0]             ctlb;
  logic                   uip, busy, upd_q, alm_q, alarm_hit;
  logic [WCW-1:0]         wcnt;

  logic acc, adv, post, time_wr, bwr, leaving, mode_chg, enc_bin, enc_h24;

  assign ld_ready = !busy && !tick;
  assign acc      = ld_valid && ld_ready;
  assign adv      = tick && !busy && (ctla[6:4] == DIV_RUN);
  assign post     = busy && osc_en && (wcnt == WLAST);
  assign time_wr  = acc && (ld_sel <= SEL_YEAR);
  assign bwr      = acc && (ld_sel == SEL_CTLB);
  assign leaving  = bwr && ctlb[MB_SET] && !ld_data[MB_SET];
  assign mode_chg = bwr && !ld_data[MB_SET] &&
                    (ctlb[MB_BIN] != ld_data[MB_BIN] || ctlb[MB_H24] != ld_data[MB_H24]);

  // visible bytes with the incoming time byte substituted
  always_comb begin
    vis_nx = vis;
    if (acc) begin
      case (ld_sel)
        SEL_SEC:  vis_nx.sec = ld_data;
        SEL_MIN:  vis_nx.min = ld_data;
        SEL_HOUR: vis_nx.hr  = ld_data;
        SEL_WDAY: vis_nx.dow = ld_data;
        SEL_MDAY: vis_nx.dom = ld_data;
        SEL_MON:  vis_nx.mon = ld_data;
        SEL_YEAR: vis_nx.yr  = ld_data;
        default:  ;
      endcase
    end
  end

  assign enc_src = leaving ? dec_c : cnt;
  assign enc_bin = bwr ? ld_data[MB_BIN] : ctlb[MB_BIN];
  assign enc_h24 = bwr ? ld_data[MB_H24] : ctlb[MB_H24];

  assign alm_cur[0] = 7'(cnt.sec);
  assign alm_cur[1] = 7'(cnt.min);
  assign alm_cur[2] = 7'(cnt.hr);

  rtc_cal_step #(.BASE_YEAR(BASE_YEAR)) u_step (
    .cur (cnt),
    .nxt (stp)
  );

  rtc_cal_decode u_dec (
    .d   (vis_nx),
    .bin (ctlb[MB_BIN]),
    .h24 (ctlb[MB_H24]),
    .c   (dec_c)
  );

  rtc_cal_encode u_enc (
    .c   (enc_src),
    .bin (enc_bin),
    .h24 (enc_h24),
    .d   (enc_v)
  );

  rtc_cal_alarm #(.NFIELD(ALM_N), .HR_IDX(ALM_HR_IDX)) u_alm (
    .en  (ctlb[MB_AIE]),
    .bin (ctlb[MB_BIN]),
    .h24 (ctlb[MB_H24]),
    .alm (alm_r),
    .cur (alm_cur),
    .hit (alarm_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= CAL_RST;
      vis   <= DISP_RST;
      alm_r <= '0;
      ctla  <= 7'h20;
      ctlb  <= 8'h02;
      uip   <= 1'b0;
      busy  <= 1'b0;
      wcnt  <= '0;
      upd_q <= 1'b0;
      alm_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      alm_q <= 1'b0;

      if (adv) begin
        cnt  <= stp;
        busy <= 1'b1;
        wcnt <= '0;
        if (!ctlb[MB_SET]) uip <= 1'b1;
      end else if (post) begin
        busy  <= 1'b0;
        uip   <= 1'b0;
        upd_q <= 1'b1;
        alm_q <= alarm_hit;
        if (!ctlb[MB_SET]) vis <= enc_v;
      end else if (busy && osc_en) begin
        wcnt <= wcnt + WCW'(1);
      end

      if (time_wr) begin
        vis <= vis_nx;
        if (!ctlb[MB_SET]) cnt <= dec_c;
      end

      if (acc) begin
        case (ld_sel)
          SEL_ASEC: alm_r[0] <= ld_data;
          SEL_AMIN: alm_r[1] <= ld_data;
          SEL_AHR:  alm_r[2] <= ld_data;
          SEL_CTLA: ctla     <= ld_data[6:0];
          default:  ;
        endcase
      end

      if (bwr) begin
        ctlb <= ld_data;
        if (leaving)  cnt <= dec_c;
        if (mode_chg) vis <= enc_v;
      end
    end
  end

  assign sec_o         = vis.sec;
  assign min_o         = vis.min;
  assign hour_o        = vis.hr;
  assign wday_o        = vis.dow;
  assign mday_o        = vis.dom;
  assign month_o       = vis.mon;
  assign year_o        = vis.yr;
  assign ctrl_a_o      = {uip, ctla};
  assign ctrl_b_o      = ctlb;
  assign alarm_flag_o  = alm_q;
  assign update_flag_o = upd_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ld_valid,
  input logic       ld_ready,
  input logic [7:0] sec_o,
  input logic [7:0] ctrl_a_o,
  input logic [7:0] ctrl_b_o,
  input logic       alarm_flag_o,
  input logic       update_flag_o
);
  // R7: no beat is accepted while an update is in progress
  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_a_o[7] |-> !ld_ready);

  // R6: the in-progress bit is already clear when the update flag appears
  p_uip_post_r6: assert property (@(posedge clk) disable iff (!rst_n)
    update_flag_o |-> !ctrl_a_o[7]);

  // R9: the update-ended flag is a single-cycle pulse
  p_flag_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    update_flag_o |=> !update_flag_o);

  // R9: an alarm only ever posts together with an update
  p_alarm_with_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag_o |-> update_flag_o);

  // R5: a tick with the divider stopped never opens a window
  p_div_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl_a_o[6:4] != 3'b010 && !ctrl_a_o[7]) |=> !ctrl_a_o[7]);

  // R8: visible seconds hold while in set mode unless a load lands
  p_set_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_b_o[7] && !(ld_valid && ld_ready)) |=> $stable(sec_o));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .ld_valid      (ld_valid),
  .ld_ready      (ld_ready),
  .sec_o         (sec_o),
  .ctrl_a_o      (ctrl_a_o),
  .ctrl_b_o      (ctrl_b_o),
  .alarm_flag_o  (alarm_flag_o),
  .update_flag_o (update_flag_o)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  import rtc_cal_pkg::*;

  localparam int BYEAR = 1900;
  localparam int UIPC  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             osc_en = 1'b1;
  logic             ld_valid = 1'b0;
  logic             ld_ready;
  logic [SEL_W-1:0] ld_sel = '0;
  logic [7:0]       ld_data = '0;
  logic [7:0]       sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o;
  logic [7:0]       ctrl_a_o, ctrl_b_o;
  logic             alarm_flag_o, update_flag_o;

  always #2 clk = ~clk;

  rtc_calendar #(.BASE_YEAR(BYEAR), .UIP_CYCLES(UIPC)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_en(osc_en),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_data(ld_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .month_o(month_o), .year_o(year_o),
    .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o),
    .alarm_flag_o(alarm_flag_o), .update_flag_o(update_flag_o)
  );

  int nchk = 0, nfail = 0;
  int ms, mm, mh, mw, md, mmo, my;
  bit mbin = 0, mh24 = 1;
  int got_upd, got_alm, uip_cnt, rdy_bad, tick_rdy_bad;

  task automatic chk(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int enc(input int v, input bit bin);
    return bin ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int enc_hr(input int h, input bit bin, input bit h24);
    if (h24) return enc(h, bin);
    return enc(h % 12, bin) + ((h >= 12) ? 128 : 0);
  endfunction

  function automatic int mdays(input int mon, input int yoff);
    int y;
    bit leap;
    y = BYEAR + yoff;
    leap = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    case (mon)
      2: return leap ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  task automatic m_step();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mw = (mw % 7) + 1;
          if (md >= mdays(mmo, my)) begin
            md = 1;
            if (mmo == 12) begin mmo = 1; my = (my + 1) % 100; end
            else mmo++;
          end else md++;
        end
      end
    end
  endtask

  task automatic load(input logic [SEL_W-1:0] s, input logic [7:0] d);
    ld_valid = 1'b1; ld_sel = s; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic set_time();
    load(SEL_SEC,  8'(enc(ms, mbin)));
    load(SEL_MIN,  8'(enc(mm, mbin)));
    load(SEL_HOUR, 8'(enc_hr(mh, mbin, mh24)));
    load(SEL_WDAY, 8'(enc(mw, mbin)));
    load(SEL_MDAY, 8'(enc(md, mbin)));
    load(SEL_MON,  8'(enc(mmo, mbin)));
    load(SEL_YEAR, 8'(enc(my, mbin)));
  endtask

  task automatic set_mode(input logic [7:0] b);
    load(SEL_CTLB, b);
    mbin = b[2];
    mh24 = b[1];
  endtask

  task automatic do_tick();
    got_upd = 0; got_alm = 0; uip_cnt = 0;
    tick = 1'b1;
    #1;
    if (ld_ready) tick_rdy_bad++;
    @(negedge clk);
    tick = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (ctrl_a_o[7]) uip_cnt++;
      if (ctrl_a_o[7] && ld_ready) rdy_bad++;
      if (update_flag_o) got_upd++;
      if (alarm_flag_o) got_alm++;
      if (ld_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " sec"},   int'(sec_o),   enc(ms, mbin));
    chk({req, " min"},   int'(min_o),   enc(mm, mbin));
    chk({req, " hour"},  int'(hour_o),  enc_hr(mh, mbin, mh24));
    chk({req, " wday"},  int'(wday_o),  enc(mw, mbin));
    chk({req, " mday"},  int'(mday_o),  enc(md, mbin));
    chk({req, " month"}, int'(month_o), enc(mmo, mbin));
    chk({req, " year"},  int'(year_o),  enc(my, mbin));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R6 update window never closed actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    tick_rdy_bad = 0; rdy_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mmo = 1; my = 0;
    check_all("R11");
    chk("R11 rate byte", int'(ctrl_a_o), 'h20);
    chk("R11 mode byte", int'(ctrl_b_o), 'h02);
    chk("R11 flags", int'({alarm_flag_o, update_flag_o}), 0);
    chk("R11 ready", int'(ld_ready), 1);

    // R1 R2 R3: BCD 24h across midnight of the last day of year offset 99
    ms = 0; mm = 58; mh = 23; mw = 7; md = 31; mmo = 12; my = 99;
    set_time();
    for (int i = 0; i < 120; i++) begin
      do_tick(); m_step();
      check_all("R1");
      chk("R9 update pulse", got_upd, 1);
    end

    // R10 then R3: switch to binary, then run
    set_mode(8'h06);
    check_all("R10 bin");
    for (int i = 0; i < 70; i++) begin
      do_tick(); m_step();
      check_all("R3 bin");
    end
    set_mode(8'h02);
    check_all("R10 bcd");

    // R4: every hour boundary in 12-hour BCD and binary
    for (int b = 0; b < 2; b++) begin
      set_mode(8'(b * 4));
      check_all("R10 h12");
      for (int h = 0; h < 24; h++) begin
        ms = 59; mm = 59; mh = h;
        set_time();
        check_all("R4 load");
        do_tick(); m_step();
        check_all("R4");
      end
    end
    set_mode(8'h02);

    // R2: month ends in ordinary, leap and century years
    for (int yi = 0; yi < 4; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        my = (yi == 0) ? 0 : (yi == 1) ? 3 : (yi == 2) ? 4 : 96;
        mmo = mo; md = mdays(mo, my); mh = 23; mm = 59; ms = 59; mw = 3;
        set_time();
        do_tick(); m_step();
        check_all("R2 month end");
      end
      my = (yi == 0) ? 0 : (yi == 1) ? 3 : (yi == 2) ? 4 : 96;
      mmo = 2; md = 28; mh = 23; mm = 59; ms = 59; mw = 5;
      set_time();
      do_tick(); m_step();
      check_all("R2 feb 28");
    end

    // R5: divider codes other than 010 stop time
    for (int dv = 0; dv < 8; dv++) begin
      if (dv != 2) begin
        load(SEL_CTLA, 8'(dv << 4));
        do_tick();
        chk("R5 no window", uip_cnt, 0);
        chk("R5 no update", got_upd, 0);
        check_all("R5");
      end
    end
    load(SEL_CTLA, 8'h20);

    // R6: window length and read-only bit
    do_tick(); m_step();
    chk("R6 window strobes", uip_cnt, UIPC);
    check_all("R6");
    load(SEL_CTLA, 8'hA0);
    chk("R6 bit7 ignored", int'(ctrl_a_o), 'h20);

    // R7: back-pressure and unused select codes
    chk("R7 ready low with tick", tick_rdy_bad, 0);
    chk("R7 ready low in window", rdy_bad, 0);
    for (int s = 12; s < 16; s++) begin
      load(4'(s), 8'h55);
      check_all("R7 unused sel");
      chk("R7 unused sel rate", int'(ctrl_a_o), 'h20);
      chk("R7 unused sel mode", int'(ctrl_b_o), 'h02);
    end

    // R8: set mode freezes display, leaving reloads counter from display
    ms = 10; mm = 5; mh = 7; mw = 2; md = 9; mmo = 6; my = 20;
    set_time();
    set_mode(8'h82);
    chk("R8 mode byte", int'(ctrl_b_o), 'h82);
    do_tick();
    chk("R8 no uip in set", uip_cnt, 0);
    chk("R9 update in set", got_upd, 1);
    check_all("R8 frozen");
    load(SEL_SEC, 8'h30);
    do_tick();
    ms = 30;
    check_all("R8 frozen after load");
    set_mode(8'h02);
    check_all("R8 leave");
    do_tick(); m_step();
    check_all("R8 reloaded");

    // R9: alarm matching
    set_mode(8'h22);
    load(SEL_ASEC, 8'h05); load(SEL_AMIN, 8'hC0); load(SEL_AHR, 8'hC0);
    ms = 4; mm = 20; mh = 10;
    set_time();
    do_tick(); m_step();
    chk("R9 wildcard hit", got_alm, 1);
    do_tick(); m_step();
    chk("R9 sec miss", got_alm, 0);
    load(SEL_AMIN, 8'h21);
    ms = 4; set_time();
    do_tick(); m_step();
    chk("R9 min miss", got_alm, 0);
    chk("R9 update on miss", got_upd, 1);
    load(SEL_AMIN, 8'h20); load(SEL_AHR, 8'h10);
    ms = 4; set_time();
    do_tick(); m_step();
    chk("R9 exact hit", got_alm, 1);
    set_mode(8'h02);
    ms = 4; set_time();
    do_tick(); m_step();
    chk("R9 disabled", got_alm, 0);
    set_mode(8'h22);
    load(SEL_ASEC, 8'hC0); load(SEL_AMIN, 8'hC0); load(SEL_AHR, 8'hC0);
    do_tick(); m_step();
    chk("R9 all wildcard", got_alm, 1);
    check_all("R9 time");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule